// File: doc/BRIEF.md
# Flash Write Protection Range Checker

This block is the access-control stage placed in front of a serial flash cycle sequencer. Each requested cycle comes with a 24-bit flash address and a flag that marks it as a write or erase. The block decides in one clock whether the cycle may go ahead. It returns either a grant pulse or a blocked pulse to the sequencer. A blocked cycle never reaches the flash pins. Instead, a sticky blocked flag is raised in the status register.

Two kinds of protection are combined. A floor register refuses every cycle, read or write, whose address lies below a programmed boundary. Three protected-range registers each hold an enable, a base page and a limit page, with 4 KiB pages. They refuse write and erase cycles whose page falls inside any enabled range. A sticky configuration lock in the status register freezes the floor and range registers until reset. All registers are reached through a simple select/write-enable port with a combinational read-back.

Top module: `flash_guard`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: the floor, every range register, the lock, the blocked flag, and both response pulses.
- R2: A request whose address is strictly below the floor (select 0, bits 23:0) is blocked, whether it is a read or a write. A request exactly at the floor address is not refused by the floor.
- R3: A write or erase request is blocked when its page (address bits 23:12) satisfies base <= page <= limit for an enabled range. Both ends are inclusive.
- R4: A range register whose enable bit (bit 31) is clear protects nothing, whatever its base and limit hold.
- R5: Read requests are never checked against the protected ranges.
- R6: Exactly one of grant or blocked pulses, for one cycle, in the clock after each request. Neither pulses without a request.
- R7: The blocked flag is status bit 3 (select 4). It is set by every blocked request and stays set. Writing 1 to bit 3 clears it, and writing 0 leaves it unchanged. A block in the same cycle as a clear leaves the flag set.
- R8: Writing 1 to status bit 15 sets the lock, which clears only on reset. While the lock is set, writes to the floor and range registers are dropped.
- R9: Range registers (selects 1 to 3) hold the enable in bit 31, the limit page in bits 23:12 and the base page in bits 11:0. Other bits read back as 0, and the floor reads back only bits 23:0.
- R10: The three ranges act independently, and a hit in any enabled range blocks a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 floor, 1..3 ranges, 4 status |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read-back of the selected register |
| req_valid | input | 1 | Cycle request from the sequencer |
| req_addr | input | 24 | Flash address of the requested cycle |
| req_write | input | 1 | Request is a write or erase cycle |
| gnt_valid | output | 1 | Grant pulse, one clock after the request |
| blk_valid | output | 1 | Blocked pulse, one clock after the request |
| blocked_flag | output | 1 | Sticky blocked status flag |

## Verification
A wrong register field, a stuck enable or an off-by-one comparator shows at the ports as a grant where a blocked pulse was due, or the reverse. It appears in the very next clock after the first request that lands on a page boundary or on the floor address. Lost or corrupted register state also shows at once in the combinational read-back. A lock or flag that fails to hold shows in the next read of the status register, or on the next write that should have been dropped. The bench keeps a behavioural model of all of this and compares every port on every clock, across both directed boundary cases and a long stretch of random traffic.

// File: rtl/flash_guard_pkg.sv
// Shared constants and types for the flash access guard.
// Assumes a 32-bit configuration word; bit positions are fixed because
// software and the sequencer decode them.
package flash_guard_pkg;
    localparam int CFG_W        = 32;
    localparam int STS_LOCK_BIT = 15;
    localparam int STS_BLK_BIT  = 3;
    localparam int RNG_EN_BIT   = 31;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_GRANT = 2'd1,
        RSP_BLOCK = 2'd2
    } rsp_e;
endpackage

// File: rtl/flash_guard_regs.sv
// Configuration registers: floor, protected ranges and the sticky lock.
// Assumes one write per clock through cfg_we/cfg_sel; writes to floor and
// ranges are dropped while the lock is set. Emits a clear strobe for the
// blocked flag, which lives in the decision stage.
module flash_guard_regs
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int PAGE_SHIFT = 12,
    parameter int NUM_RANGES = 3,
    parameter int SEL_W      = 3
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        cfg_we,
    input  logic [SEL_W-1:0]                            cfg_sel,
    input  logic [CFG_W-1:0]                            cfg_wdata,
    output logic [ADDR_W-1:0]                           floor_q,
    output logic [NUM_RANGES-1:0]                       rng_en_q,
    output logic [NUM_RANGES-1:0][ADDR_W-PAGE_SHIFT-1:0] rng_base_q,
    output logic [NUM_RANGES-1:0][ADDR_W-PAGE_SHIFT-1:0] rng_limit_q,
    output logic                                        lock_q,
    output logic                                        flag_clr
);
    localparam int PG_W = ADDR_W - PAGE_SHIFT;
    localparam logic [SEL_W-1:0] SEL_FLOOR  = '0;
    localparam logic [SEL_W-1:0] SEL_STATUS = SEL_W'(NUM_RANGES + 1);

    logic sts_wr;
    logic unused_wdata;

    assign sts_wr       = cfg_we && (cfg_sel == SEL_STATUS);
    assign flag_clr     = sts_wr && cfg_wdata[STS_BLK_BIT];
    assign unused_wdata = ^cfg_wdata[RNG_EN_BIT-1:2*PG_W];

    // Floor register: writable only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            floor_q <= '0;
        end else if (cfg_we && !lock_q && cfg_sel == SEL_FLOOR) begin
            floor_q <= cfg_wdata[ADDR_W-1:0];
        end
    end

    // One register per protected range, each frozen by the lock.
    generate
        for (genvar g = 0; g < NUM_RANGES; g++) begin : g_rng
            localparam logic [SEL_W-1:0] SEL_ME = SEL_W'(g + 1);
            // Range g: enable, limit page and base page fields.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rng_en_q[g]    <= 1'b0;
                    rng_base_q[g]  <= '0;
                    rng_limit_q[g] <= '0;
                end else if (cfg_we && !lock_q && cfg_sel == SEL_ME) begin
                    rng_en_q[g]    <= cfg_wdata[RNG_EN_BIT];
                    rng_limit_q[g] <= cfg_wdata[2*PG_W-1:PG_W];
                    rng_base_q[g]  <= cfg_wdata[PG_W-1:0];
                end
            end
        end
    endgenerate

    // Sticky lock: set by status bit 15, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (sts_wr && cfg_wdata[STS_LOCK_BIT]) begin
            lock_q <= 1'b1;
        end
    end

    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_q) |-> lock_q);

    a_r8_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_q) |-> ($stable(floor_q) && $stable(rng_en_q)
                           && $stable(rng_base_q) && $stable(rng_limit_q)));
endmodule

// File: rtl/flash_guard_range_cmp.sv
// Page comparator for one protected range.
// Assumes base and limit are page numbers; the hit is inclusive at both ends
// and is suppressed when the range is disabled.
module flash_guard_range_cmp #(
    parameter int PG_W = 12
) (
    input  logic            en,
    input  logic [PG_W-1:0] base,
    input  logic [PG_W-1:0] limit,
    input  logic [PG_W-1:0] page,
    output logic            hit
);
    // Inclusive window test on the request page.
    always_comb begin
        hit = en && (page >= base) && (page <= limit);
    end
endmodule

// File: rtl/flash_guard_decide.sv
// Decision stage: combines the floor test with the range hits and returns
// a registered grant or blocked pulse one clock after each request.
// Also holds the sticky blocked flag; a new block wins over a clear.
module flash_guard_decide
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int NUM_RANGES = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     floor_addr,
    input  logic [NUM_RANGES-1:0] range_hit,
    input  logic                  flag_clr,
    output logic                  gnt_valid,
    output logic                  blk_valid,
    output logic                  blocked_flag
);
    rsp_e rsp_q;
    logic below_floor;
    logic deny;

    // Refusal: below the floor for any cycle, or a range hit for writes.
    always_comb begin
        below_floor = req_addr < floor_addr;
        deny        = below_floor || (req_write && (|range_hit));
    end

    // Registered response, one clock after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= RSP_IDLE;
        end else if (!req_valid) begin
            rsp_q <= RSP_IDLE;
        end else begin
            rsp_q <= deny ? RSP_BLOCK : RSP_GRANT;
        end
    end

    // Sticky blocked flag with write-one-to-clear; set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blocked_flag <= 1'b0;
        end else if (req_valid && deny) begin
            blocked_flag <= 1'b1;
        end else if (flag_clr) begin
            blocked_flag <= 1'b0;
        end
    end

    assign gnt_valid = (rsp_q == RSP_GRANT);
    assign blk_valid = (rsp_q == RSP_BLOCK);

    a_r6_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gnt_valid, blk_valid}));

    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid || blk_valid) |-> $past(req_valid));

    a_r6_always_answer: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (gnt_valid || blk_valid));

    a_r7_flag_on_block: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |-> blocked_flag);

    a_r2_floor_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_addr < floor_addr)) |=> blk_valid);

    a_r3_write_hit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && (|range_hit)) |=> blk_valid);

    a_r5_read_ignores_ranges: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && (req_addr >= floor_addr)) |=> gnt_valid);
endmodule

// File: rtl/flash_guard.sv
// Top of the flash access guard: configuration registers, one comparator
// per protected range, and the decision stage. Read-back is combinational
// from the selected register. Assumes the sequencer holds off the SPI cycle
// until it sees grant.
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int PAGE_SHIFT = 12,
    parameter int NUM_RANGES = 3,
    parameter int SEL_W      = $clog2(NUM_RANGES + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              gnt_valid,
    output logic              blk_valid,
    output logic              blocked_flag
);
    localparam int PG_W = ADDR_W - PAGE_SHIFT;
    localparam logic [SEL_W-1:0] SEL_FLOOR  = '0;
    localparam logic [SEL_W-1:0] SEL_STATUS = SEL_W'(NUM_RANGES + 1);

    logic [ADDR_W-1:0]                 floor_q;
    logic [NUM_RANGES-1:0]             rng_en_q;
    logic [NUM_RANGES-1:0][PG_W-1:0]   rng_base_q;
    logic [NUM_RANGES-1:0][PG_W-1:0]   rng_limit_q;
    logic                              lock_q;
    logic                              flag_clr;
    logic [NUM_RANGES-1:0]             range_hit;
    logic [PG_W-1:0]                   req_page;

    assign req_page = req_addr[ADDR_W-1:PAGE_SHIFT];

    flash_guard_regs #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .NUM_RANGES (NUM_RANGES),
        .SEL_W      (SEL_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .floor_q     (floor_q),
        .rng_en_q    (rng_en_q),
        .rng_base_q  (rng_base_q),
        .rng_limit_q (rng_limit_q),
        .lock_q      (lock_q),
        .flag_clr    (flag_clr)
    );

    generate
        for (genvar g = 0; g < NUM_RANGES; g++) begin : g_cmp
            flash_guard_range_cmp #(.PG_W(PG_W)) u_cmp (
                .en    (rng_en_q[g]),
                .base  (rng_base_q[g]),
                .limit (rng_limit_q[g]),
                .page  (req_page),
                .hit   (range_hit[g])
            );
        end
    endgenerate

    flash_guard_decide #(
        .ADDR_W     (ADDR_W),
        .NUM_RANGES (NUM_RANGES)
    ) u_decide (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_write    (req_write),
        .floor_addr   (floor_q),
        .range_hit    (range_hit),
        .flag_clr     (flag_clr),
        .gnt_valid    (gnt_valid),
        .blk_valid    (blk_valid),
        .blocked_flag (blocked_flag)
    );

    // Read-back multiplexer over floor, ranges and status.
    always_comb begin
        cfg_rdata = '0;
        if (cfg_sel == SEL_FLOOR) begin
            cfg_rdata[ADDR_W-1:0] = floor_q;
        end
        if (cfg_sel == SEL_STATUS) begin
            cfg_rdata[STS_LOCK_BIT] = lock_q;
            cfg_rdata[STS_BLK_BIT]  = blocked_flag;
        end
        for (int i = 0; i < NUM_RANGES; i++) begin
            if (cfg_sel == SEL_W'(i + 1)) begin
                cfg_rdata[RNG_EN_BIT]        = rng_en_q[i];
                cfg_rdata[2*PG_W-1:PG_W]     = rng_limit_q[i];
                cfg_rdata[PG_W-1:0]          = rng_base_q[i];
            end
        end
    end

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |=> (!gnt_valid && !blk_valid && !blocked_flag));
endmodule

// File: tb/flash_guard_bench.sv
module flash_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = 24'd0;
    logic        req_write = 1'b0;
    logic        gnt_valid;
    logic        blk_valid;
    logic        blocked_flag;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    flash_guard u_flash_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_sel      (cfg_sel),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_write    (req_write),
        .gnt_valid    (gnt_valid),
        .blk_valid    (blk_valid),
        .blocked_flag (blocked_flag)
    );

    // Behavioural reference model
    int unsigned m_floor;
    int unsigned m_rng [3];
    bit m_lock, m_flag, m_gnt, m_blk;

    always @(posedge clk) begin
        bit deny;
        bit nflag;
        int unsigned pg;
        if (!rst_n) begin
            m_floor = 0;
            foreach (m_rng[i]) m_rng[i] = 0;
            m_lock = 0; m_flag = 0; m_gnt = 0; m_blk = 0;
        end else begin
            deny = 0;
            pg = int'(req_addr) / 4096;
            if (req_valid) begin
                if (int'(req_addr) < m_floor) deny = 1;
                if (req_write)
                    foreach (m_rng[i])
                        if (m_rng[i][31] && pg >= (m_rng[i] % 4096)
                            && pg <= ((m_rng[i] / 4096) % 4096)) deny = 1;
            end
            nflag = m_flag;
            if (cfg_we && cfg_sel == 3'd4 && cfg_wdata[3]) nflag = 0;
            if (req_valid && deny) nflag = 1;
            if (cfg_we && !m_lock) begin
                if (cfg_sel == 3'd0) m_floor = cfg_wdata % (1 << 24);
                else if (cfg_sel >= 3'd1 && cfg_sel <= 3'd3)
                    m_rng[cfg_sel - 3'd1] = cfg_wdata & 32'h80FF_FFFF;
            end
            if (cfg_we && cfg_sel == 3'd4 && cfg_wdata[15]) m_lock = 1;
            m_gnt = req_valid && !deny;
            m_blk = req_valid && deny;
            m_flag = nflag;
        end
    end

    function automatic logic [31:0] model_rdata(logic [2:0] s);
        case (s)
            3'd0: return m_floor;
            3'd1, 3'd2, 3'd3: return m_rng[s - 3'd1];
            3'd4: return (m_lock ? 32'h8000 : 0) | (m_flag ? 32'h8 : 0);
            default: return 0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock, then compare every output against the model.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        chk("R6 grant vs model", gnt_valid, m_gnt);
        chk("R6 blocked vs model", blk_valid, m_blk);
        chk("R7 flag vs model", blocked_flag, m_flag);
        chk("R9 readback vs model", cfg_rdata, model_rdata(cfg_sel));
    endtask

    task automatic wr(logic [2:0] s, logic [31:0] d);
        cfg_we = 1; cfg_sel = s; cfg_wdata = d;
        step();
        cfg_we = 0;
    endtask

    task automatic rq(logic [23:0] a, logic w);
        req_valid = 1; req_addr = a; req_write = w;
        step();
        req_valid = 0;
    endtask

    task automatic peek(string tag, logic [2:0] s, logic [31:0] exp);
        cfg_sel = s;
        #1;
        chk(tag, cfg_rdata, exp);
    endtask

    task automatic resp(string tag, logic eg, logic eb);
        chk(tag, {gnt_valid, blk_valid}, {eg, eb});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        rst_n = 0;
        repeat (3) step();
        rst_n = 1;
        for (int s = 0; s < 5; s++) peek("R1 reset readback", 3'(s), 32'd0);
        chk("R1 reset outputs", {gnt_valid, blk_valid, blocked_flag}, 3'b000);

        rq(24'h000000, 0);           resp("R6 plain read granted", 1, 0);

        wr(3'd0, 32'h0010_0000);
        rq(24'h0FFFFF, 0);           resp("R2 below floor read", 0, 1);
        chk("R7 flag set", blocked_flag, 1);
        rq(24'h100000, 1);           resp("R2 at floor granted", 1, 0);
        chk("R7 flag sticky", blocked_flag, 1);
        wr(3'd4, 32'h0000_0000);     chk("R7 write zero keeps flag", blocked_flag, 1);
        wr(3'd4, 32'h0000_0008);     chk("R7 write one clears", blocked_flag, 0);

        wr(3'd1, 32'h8020_5200);
        rq(24'h200000, 1);           resp("R3 base edge", 0, 1);
        rq(24'h205FFF, 1);           resp("R3 limit edge", 0, 1);
        rq(24'h206000, 1);           resp("R3 past limit", 1, 0);
        rq(24'h1FFFFF, 1);           resp("R3 before base", 1, 0);
        rq(24'h203000, 0);           resp("R5 read in range", 1, 0);

        wr(3'd2, 32'h003F_F300);
        rq(24'h350000, 1);           resp("R4 disabled range", 1, 0);
        peek("R9 range fields", 3'd2, 32'h003F_F300);

        wr(3'd3, 32'hFFFF_FFFF);
        peek("R9 masked bits", 3'd3, 32'h80FF_FFFF);
        rq(24'hFFF000, 1);           resp("R10 third range", 0, 1);
        wr(3'd3, 32'h8040_0400);
        rq(24'h400800, 1);           resp("R10 single page", 0, 1);
        rq(24'h401000, 1);           resp("R10 next page", 1, 0);

        wr(3'd0, 32'hFF10_0000);
        peek("R9 floor width", 3'd0, 32'h0010_0000);

        wr(3'd4, 32'h8);
        cfg_we = 1; cfg_sel = 3'd4; cfg_wdata = 32'h8;
        req_valid = 1; req_addr = 24'h000010; req_write = 0;
        step();
        cfg_we = 0; req_valid = 0;
        chk("R7 set wins over clear", blocked_flag, 1);

        for (int n = 0; n < 1500; n++) begin
            cfg_we    = ($urandom % 8) == 0;
            cfg_sel   = 3'($urandom % 6);
            cfg_wdata = $urandom & 32'hFFFF_7FFF;
            if (cfg_sel == 3'd0) cfg_wdata = cfg_wdata & 32'h003F_FFFF;
            req_valid = ($urandom % 2) == 1;
            req_addr  = 24'($urandom) & 24'h7F_FFFF;
            req_write = ($urandom % 2) == 1;
            step();
        end
        cfg_we = 0; req_valid = 0;

        wr(3'd0, 32'h0008_0000);
        wr(3'd1, 32'h8020_5200);
        wr(3'd4, 32'h8);
        wr(3'd4, 32'h8000);
        peek("R8 lock set", 3'd4, 32'h0000_8000);
        wr(3'd0, 32'h0);
        peek("R8 floor frozen", 3'd0, 32'h0008_0000);
        wr(3'd1, 32'h0);
        rq(24'h200000, 1);           resp("R8 range frozen", 0, 1);
        wr(3'd4, 32'h8);
        peek("R8 lock survives clear", 3'd4, 32'h0000_8000);

        rst_n = 0;
        step();
        rst_n = 1;
        peek("R1 reset clears lock", 3'd4, 32'd0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule